// File: doc/BRIEF.md
# Masked Vector Pack and Spread Unit

This block rearranges the elements of a 512-bit vector under the control of a per-element mask. In pack mode (compress) it gathers the elements whose mask bit is set and lays them out densely, in ascending order, from the lowest element slot upward. In spread mode (expand) it takes consecutive elements from the low end of the source and places them, one by one, into the slots whose mask bit is set. A slot's position is decided by a running count of set mask bits, not by a fixed index.

Slots that receive no source element are either cleared or copied from a separate merge vector, depending on a fill select. Element width is chosen per operation among 8, 16, 32 and 64 bits. The operation is launched by a one-cycle start pulse. The result is registered and reported with a one-cycle done pulse on the following clock. Only the register form is provided. The result register keeps its value until the next start.

Top module: `mce_unit`

## Requirements
- R1: After reset, `done` is 0 and `result` is all zeros.
- R2: `done` is 1 exactly in the cycle after a cycle with `start` high, and 0 after a cycle with `start` low. `result` carries the new value from that same cycle.
- R3: In pack mode (`mode`=0), result slot k, for k below the number of set mask bits, holds the source element at the position of the (k+1)-th set mask bit, counting from bit 0.
- R4: In pack mode, result slots at or above the number of set mask bits are 0 when `zero_fill`=1. When `zero_fill`=0 they equal the same slot of `dst`.
- R5: In spread mode (`mode`=1), the slot of the k-th set mask bit (k counted from 0, starting at bit 0) receives source element k.
- R6: In spread mode, slots whose mask bit is clear are 0 when `zero_fill`=1. When `zero_fill`=0 they equal the same slot of `dst`.
- R7: `esize` encodes element width: 0 for 8 bits (64 slots), 1 for 16 bits (32 slots), 2 for 32 bits (16 slots) and 3 for 64 bits (8 slots). Slot k occupies bits [k*W +: W].
- R8: Only the low N mask bits are used, where N is 512 divided by the element width. Mask bits at N and above have no effect on the result.
- R9: An all-zero mask yields an all-zero result in zeroing mode and a copy of `dst` in merge mode, in both modes.
- R10: A mask whose low N bits are all set yields a copy of `src`, in both modes and both fill settings.
- R11: `result` holds its value in every cycle that follows a cycle without `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one operation; operands are sampled on this edge |
| mode | input | 1 | 0 = pack (compress), 1 = spread (expand) |
| zero_fill | input | 1 | 1 = clear unwritten slots, 0 = take them from `dst` |
| esize | input | 2 | Element width select (see R7) |
| mask | input | 64 | Per-element select bits, bit i for slot i |
| src | input | 512 | Source vector |
| dst | input | 512 | Merge vector for unwritten slots |
| result | output | 512 | Registered result |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest case to reach from the ports is the one where the highest pack slot, or the highest spread slot, is fed from the far end of the vector. This happens with only one or two mask bits set at opposite ends of the active range. At the same time the mask bits above N must carry noise, so that a wrong slot count or a widening error shows up. Uniform random masks almost never produce these shapes. The stimulus therefore mixes masks of several densities, made by ANDing and ORing random words together. It adds directed vectors with single end bits, with empty and full masks, and with noise above N at every width.

// File: rtl/mce_pkg.sv
package mce_pkg;

   typedef enum logic [1:0] {
      ESZ_B8  = 2'd0,
      ESZ_H16 = 2'd1,
      ESZ_W32 = 2'd2,
      ESZ_D64 = 2'd3
   } esize_e;

   typedef enum logic {
      OP_PACK   = 1'b0,
      OP_SPREAD = 1'b1
   } op_e;

   localparam int unsigned NUM_SIZES = 4;

endpackage

// File: rtl/mce_mask_widen.sv
// Turns the element mask into one enable per byte lane. An element of
// 2**s bytes owns byte lanes [e*2**s +: 2**s], so lane b follows mask[b>>s].
// Mask bits above the active element count are never addressed.
module mce_mask_widen
   import mce_pkg::*;
#(
   parameter int unsigned LANES     = 64,
   parameter int unsigned MASK_W    = 64,
   parameter bit          NARROW_EN = 1'b1
) (
   input  logic [1:0]        esize,
   input  logic [MASK_W-1:0] mask,
   output logic [LANES-1:0]  lane_en
);

   initial begin
      assert (MASK_W >= LANES)
         else $error("mce_mask_widen: MASK_W must cover one bit per byte lane");
      assert (LANES >= 8 && (LANES & (LANES - 1)) == 0)
         else $error("mce_mask_widen: LANES must be a power of two, at least 8");
   end

   logic [LANES-1:0] cand [NUM_SIZES];
   logic [1:0]       size_sel;

   for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_size
      for (genvar gb = 0; gb < LANES; gb++) begin : g_lane
         assign cand[gs][gb] = mask[gb >> gs];
      end
   end

   if (NARROW_EN) begin : g_narrow
      assign size_sel = esize;
   end else begin : g_wide_only
      // without narrow support, byte and halfword selects run as 32-bit
      assign size_sel = esize[1] ? esize : 2'(ESZ_W32);
   end

   assign lane_en = cand[size_sel];

endmodule

// File: rtl/mce_prefix.sv
// Running count of enabled lanes below each lane, plus the total.
module mce_prefix #(
   parameter int unsigned LANES = 64,
   localparam int unsigned CW   = $clog2(LANES) + 1
) (
   input  logic [LANES-1:0] lane_en,
   output logic [CW-1:0]    pre [LANES],
   output logic [CW-1:0]    total
);

   assign pre[0] = '0;

   for (genvar gi = 1; gi < LANES; gi++) begin : g_chain
      assign pre[gi] = pre[gi-1] + CW'(lane_en[gi-1]);
   end

   assign total = pre[LANES-1] + CW'(lane_en[LANES-1]);

endmodule

// File: rtl/mce_lane_route.sv
// Byte-lane crossbar. Pack writes each enabled lane to the slot given by its
// prefix count; spread reads, for each enabled lane, the source lane given by
// its prefix count. Unwritten lanes take the fill value.
module mce_lane_route
   import mce_pkg::*;
#(
   parameter int unsigned LANES = 64,
   parameter int unsigned LW    = 8,
   localparam int unsigned CW   = $clog2(LANES) + 1,
   localparam int unsigned IW   = $clog2(LANES),
   localparam int unsigned VW   = LANES * LW
) (
   input  op_e              op,
   input  logic             zero_fill,
   input  logic [LANES-1:0] lane_en,
   input  logic [CW-1:0]    pre [LANES],
   input  logic [CW-1:0]    total,
   input  logic [VW-1:0]    src,
   input  logic [VW-1:0]    dst,
   output logic [VW-1:0]    route
);

   logic [LW-1:0] s_l    [LANES];
   logic [LW-1:0] fill_l [LANES];
   logic [LW-1:0] pack_l [LANES];
   logic [LW-1:0] sprd_l [LANES];

   for (genvar gl = 0; gl < LANES; gl++) begin : g_unpack
      assign s_l[gl]    = src[gl*LW +: LW];
      assign fill_l[gl] = zero_fill ? '0 : dst[gl*LW +: LW];
      assign route[gl*LW +: LW] = (op == OP_SPREAD) ? sprd_l[gl] : pack_l[gl];
   end

   // pack: scatter each enabled lane down to its dense slot
   always_comb begin
      for (int j = 0; j < LANES; j++) begin
         pack_l[j] = (CW'(j) >= total) ? fill_l[j] : '0;
      end
      for (int i = 0; i < LANES; i++) begin
         if (lane_en[i]) begin
            pack_l[pre[i][IW-1:0]] = s_l[i];
         end
      end
   end

   // spread: each enabled lane pulls the next dense source lane
   always_comb begin
      for (int j = 0; j < LANES; j++) begin
         sprd_l[j] = lane_en[j] ? s_l[pre[j][IW-1:0]] : fill_l[j];
      end
   end

endmodule

// File: rtl/mce_unit.sv
module mce_unit
   import mce_pkg::*;
#(
   parameter int unsigned VEC_W     = 512,
   parameter int unsigned MASK_W    = 64,
   parameter bit          NARROW_EN = 1'b1,
   localparam int unsigned LW       = 8,
   localparam int unsigned LANES    = VEC_W / LW,
   localparam int unsigned CW       = $clog2(LANES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode,
   input  logic              zero_fill,
   input  logic [1:0]        esize,
   input  logic [MASK_W-1:0] mask,
   input  logic [VEC_W-1:0]  src,
   input  logic [VEC_W-1:0]  dst,
   output logic [VEC_W-1:0]  result,
   output logic              done
);

   initial begin
      assert (VEC_W % (8 * LW) == 0)
         else $error("mce_unit: VEC_W must hold a whole number of 64-bit elements");
   end

   logic [LANES-1:0] lane_en;
   logic [CW-1:0]    pre [LANES];
   logic [CW-1:0]    total;
   logic [VEC_W-1:0] route;

   mce_mask_widen #(
      .LANES     (LANES),
      .MASK_W    (MASK_W),
      .NARROW_EN (NARROW_EN)
   ) u_widen (
      .esize   (esize),
      .mask    (mask),
      .lane_en (lane_en)
   );

   mce_prefix #(
      .LANES (LANES)
   ) u_prefix (
      .lane_en (lane_en),
      .pre     (pre),
      .total   (total)
   );

   mce_lane_route #(
      .LANES (LANES),
      .LW    (LW)
   ) u_route (
      .op        (op_e'(mode)),
      .zero_fill (zero_fill),
      .lane_en   (lane_en),
      .pre       (pre),
      .total     (total),
      .src       (src),
      .dst       (dst),
      .route     (route)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         done   <= 1'b0;
      end else begin
         done <= start;
         if (start) begin
            result <= route;
         end
      end
   end

   p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);

   p_no_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);

   p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(result));

   p_full_mask_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (&lane_en)) |=> (result == $past(src)));

   p_empty_mask_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && lane_en == '0 && zero_fill) |=> (result == '0));

   p_empty_mask_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && lane_en == '0 && !zero_fill) |=> (result == $past(dst)));

endmodule

// File: tb/tb_mce_unit.sv
`timescale 1ns/1ps
module tb_mce_unit;

   localparam int VW = 512;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic          mode;
   logic          zero_fill;
   logic [1:0]    esize;
   logic [63:0]   mask;
   logic [VW-1:0] src;
   logic [VW-1:0] dst;
   logic [VW-1:0] result;
   logic          done;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   mce_unit dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode      (mode),
      .zero_fill (zero_fill),
      .esize     (esize),
      .mask      (mask),
      .src       (src),
      .dst       (dst),
      .result    (result),
      .done      (done)
   );

   // reference built from the requirements, working per element of W bytes
   function automatic logic [VW-1:0] model(input logic op, input logic zf,
                                           input logic [1:0] es, input logic [63:0] m,
                                           input logic [VW-1:0] s, input logic [VW-1:0] d);
      logic [VW-1:0] r;
      int wb = 1 << es;
      int n  = 64 / wb;
      int k  = 0;
      r = zf ? '0 : d;
      if (!op) begin
         for (int i = 0; i < n; i++) begin
            if (m[i]) begin
               for (int b = 0; b < wb; b++) r[(k*wb+b)*8 +: 8] = s[(i*wb+b)*8 +: 8];
               k++;
            end
         end
      end else begin
         for (int j = 0; j < n; j++) begin
            if (m[j]) begin
               for (int b = 0; b < wb; b++) r[(j*wb+b)*8 +: 8] = s[(k*wb+b)*8 +: 8];
               k++;
            end
         end
      end
      return r;
   endfunction

   function automatic logic [VW-1:0] rand_vec();
      logic [VW-1:0] v;
      for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [63:0] rand_mask();
      logic [63:0] a, b, c;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      c = {$urandom, $urandom};
      case ($urandom % 4)
         0: return a;
         1: return a & b;
         2: return a | b;
         default: return a & b & c;
      endcase
   endfunction

   task automatic check_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: result %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic run_op(input string req, input logic op, input logic zf,
                         input logic [1:0] es, input logic [63:0] m,
                         input logic [VW-1:0] s, input logic [VW-1:0] d);
      logic [VW-1:0] exp;
      exp = model(op, zf, es, m, s, d);
      @(negedge clk);
      mode = op; zero_fill = zf; esize = es; mask = m; src = s; dst = d;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check_vec(req, result, exp);
      check_bit({req, " R2 done pulse"}, done, 1'b1);
      // scramble the operands while idle: the result must not move
      src = rand_vec(); dst = rand_vec(); mask = rand_mask();
      @(negedge clk);
      check_bit("R2 done low after pulse", done, 1'b0);
      check_vec("R11 result held", result, exp);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 200000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      logic [VW-1:0] s0, d0;
      logic [63:0]   m0;
      void'($urandom(32'h5EED_C0DE));
      rst_n = 1'b0; start = 1'b0; mode = 1'b0; zero_fill = 1'b0;
      esize = 2'd0; mask = '0; src = '0; dst = '0;
      repeat (3) @(negedge clk);
      check_vec("R1 reset result", result, '0);
      check_bit("R1 reset done", done, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1 done idle after reset", done, 1'b0);

      s0 = rand_vec(); d0 = rand_vec();
      // R9: empty mask, every width, both modes, both fills
      for (int es = 0; es < 4; es++) begin
         run_op("R9 empty mask pack zero",    1'b0, 1'b1, 2'(es), 64'h0, s0, d0);
         run_op("R9 empty mask spread merge", 1'b1, 1'b0, 2'(es), 64'h0, s0, d0);
      end
      // R10: full low mask with noise above N is still a copy
      for (int es = 0; es < 4; es++) begin
         m0 = (es == 0) ? 64'hFFFF_FFFF_FFFF_FFFF
                        : ((64'd1 << (64 >> es)) - 64'd1) | ({$urandom, $urandom} << (64 >> es));
         run_op("R10 full mask pack",   1'b0, 1'b0, 2'(es), m0, s0, d0);
         run_op("R10 full mask spread", 1'b1, 1'b1, 2'(es), m0, s0, d0);
      end
      // R3/R5: single end bits move elements across the whole vector
      run_op("R3 pack top element to slot 0 64b",  1'b0, 1'b1, 2'd3, 64'h80, s0, d0);
      run_op("R3 pack top byte to slot 0",         1'b0, 1'b0, 2'd0, 64'h8000_0000_0000_0000, s0, d0);
      run_op("R5 spread element 0 to top 64b",     1'b1, 1'b1, 2'd3, 64'h80, s0, d0);
      run_op("R5 spread byte 0 to top",            1'b1, 1'b0, 2'd0, 64'h8000_0000_0000_0000, s0, d0);
      run_op("R3 R4 pack ends 32b merge",          1'b0, 1'b0, 2'd2, 64'h8001, s0, d0);
      run_op("R5 R6 spread ends 16b zero",         1'b1, 1'b1, 2'd1, 64'h8000_0001, s0, d0);
      // R8: bits above N only, must act as an empty mask
      run_op("R8 upper bits ignored 64b",          1'b0, 1'b0, 2'd3, 64'hFFFF_FFFF_FFFF_FF00, s0, d0);
      run_op("R8 upper bits ignored 32b spread",   1'b1, 1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_0000, s0, d0);
      run_op("R8 upper bits ignored 16b spread",   1'b1, 1'b0, 2'd1, 64'hA5A5_5A5A_0000_0000, s0, d0);

      // constrained random: R3 R4 R5 R6 R7 R8 across widths, modes and fills
      for (int t = 0; t < 400; t++) begin
         logic          op, zf;
         logic [1:0]    es;
         op = 1'($urandom);
         zf = 1'($urandom);
         es = 2'($urandom);
         run_op(op ? "R5 R6 R7 R8 random spread" : "R3 R4 R7 R8 random pack",
                op, zf, es, rand_mask(), rand_vec(), rand_vec());
      end

      // start held for consecutive cycles: each edge loads a new result
      @(negedge clk);
      s0 = rand_vec(); d0 = rand_vec();
      mode = 1'b0; zero_fill = 1'b1; esize = 2'd2; mask = 64'h00F0; src = s0; dst = d0;
      start = 1'b1;
      @(negedge clk);
      check_vec("R2 back-to-back first", result, model(1'b0, 1'b1, 2'd2, 64'h00F0, s0, d0));
      mode = 1'b1; mask = 64'h0F00;
      @(negedge clk);
      start = 1'b0;
      check_vec("R2 back-to-back second", result, model(1'b1, 1'b1, 2'd2, 64'h0F00, s0, d0));
      check_bit("R2 done still high", done, 1'b1);
      @(negedge clk);
      check_bit("R2 done drops", done, 1'b0);

      finish_run();
   end

endmodule